// File: doc/BRIEF.md
# Register Shadow Tracker

This block watches a processor from the outside and keeps a best-effort copy of its accumulator (A), its two index registers (X and Y) and its four condition flags: negative (N), overflow (V), zero (Z) and carry (C). It cannot see the processor's internal state. It sees only a stream of instruction records from an upstream bus classifier. Each record carries the opcode byte, the last data byte that crossed the bus during that instruction (read or written), and, for conditional branches, whether the branch was taken.

Every shadowed value has a private known bit. A value becomes known when an instruction exposes it on the bus. It stays known while later instructions derive new values only from known inputs. It becomes unknown when an instruction changes it in a way the bus does not reveal. All addressing modes of an operation use the same update, and the recorded bus byte serves as the operand. Arithmetic is binary only. Memory contents and the program counter are not tracked.

A record is taken in on a rising clock edge where `recValid` is high. The updated shadow state appears on the outputs directly after that edge.

Top module: `shadow_tracker`

## Requirements
- R1: When reset is asserted (active low, asynchronous), every known bit clears: A, X, Y and all four flags read as unknown.
- R2: A record is ignored, and all shadow values and known bits hold, in two cases: `recValid` is low, or the opcode belongs to no group listed in R3 to R14 (for example 0x4C or 0xEA).
- R3: Load opcodes set the target register to the bus byte and mark it known. They also make N known as bit 7 of the byte and Z known as (byte == 0). The load opcodes are: for A, 0x68 and every opcode with bits[1:0]=01 and bits[7:5]=101; for X, 0xA2, 0xA6, 0xAE, 0xB6 and 0xBE; for Y, 0xA0, 0xA4, 0xAC, 0xB4 and 0xBC.
- R4: Store opcodes set the source register to the bus byte and mark it known, with the flags unchanged. The store opcodes are: for A, 0x48 and every opcode with bits[1:0]=01 and bits[7:5]=100, except 0x89; for X, 0x86, 0x8E and 0x96; for Y, 0x84, 0x8C and 0x94.
- R5: Opcodes with bits[1:0]=01 and bits[7:5] equal to 000, 001, 010, 011 or 111 combine A with the bus byte, by OR, AND, XOR, add with carry, or subtract with borrow (A + ~byte + C) respectively. The result and its N and Z are known only if A is known, and for the add and subtract forms also only if C is known. The add and subtract forms also produce C and V, under the same condition.
- R6: Compare opcodes work against the bus byte: A for bits[1:0]=01 with bits[7:5]=110; X for 0xE0, 0xE4 and 0xEC; Y for 0xC0, 0xC4 and 0xCC. They set C = (reg >= byte), Z = (reg == byte) and N = bit 7 of (reg − byte). These flags are known only if the register is known. The register does not change.
- R7: The copies A→X (0xAA), A→Y (0xA8), X→A (0x8A) and Y→A (0x98) pass both the value and its known bit, and take N and Z from the copied value. Copying the stack pointer into X (0xBA) makes X, N and Z unknown.
- R8: Copying X into the stack pointer (0x9A) changes no shadow value and no known bit.
- R9: Increment X (0xE8), increment Y (0xC8), decrement X (0xCA) and decrement Y (0x88) add or subtract one modulo 256. The register keeps its known bit, and N and Z follow the result with the same known state.
- R10: Memory read-modify-write opcodes change no register. These are the opcodes with bits[1:0]=10, bit 2 = 1 and bits[7:5] in {000,001,010,011,110,111}. They make N and Z known from the bus byte (the written-back value). When bit 7 of the opcode is 0 (a shift or rotate), they also make C unknown.
- R11: The accumulator shifts are 0x0A (left), 0x2A (rotate left through C), 0x4A (right) and 0x6A (rotate right through C). Each produces the new A, N, Z and the bit shifted out into C. All of these are known only if A is known, and for the rotates also only if C was known.
- R12: 0x18 clears C, 0x38 sets C and 0xB8 clears V, and each makes that flag known. A branch opcode (bits[4:0]=10000) makes a flag known. Bits[7:6] pick the flag (00 N, 01 V, 10 C, 11 Z). The flag takes the value in bit 5 when the branch was taken, and its inverse when it was not.
- R13: Bit-test opcodes 0x24, 0x2C, 0x34 and 0x3C set Z = ((A & byte) == 0), known only if A is known. They also make N and V known as byte bits 7 and 6. The immediate form 0x89 sets only Z.
- R14: Status push (0x08) and status pull (0x28) make all four flags known from the bus byte: N = bit 7, V = bit 6, Z = bit 1, C = bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| recValid | input | 1 | A record is present this cycle |
| recOp | input | 8 | Opcode byte of the record |
| recData | input | 8 | Last bus data byte of the instruction |
| recTaken | input | 1 | Branch outcome (1 = taken); used only by branch opcodes |
| shadowA | output | 8 | Shadow accumulator value |
| shadowAKnown | output | 1 | Shadow accumulator is known |
| shadowX | output | 8 | Shadow X value |
| shadowXKnown | output | 1 | Shadow X is known |
| shadowY | output | 8 | Shadow Y value |
| shadowYKnown | output | 1 | Shadow Y is known |
| flags | output | 4 | Shadow flags {N,V,Z,C} |
| flagsKnown | output | 4 | Known bits for {N,V,Z,C} |

## Verification
A wrong known bit is the dangerous fault. A value claimed as known when it is not is reported as fact, and the error then spreads into every later register or flag derived from it. That only becomes visible at the ports when a later load or compare disagrees with the shadow. The stimulus therefore chains instructions so that each derived value is compared in the very cycle after its record, before another exposure can overwrite it. The chains cover known-to-unknown transitions (stack copy, add with an unknown carry) and unknown-to-known recovery (loads, status pull). Carry and overflow are exercised through both signed-overflow and borrow cases, so an error in carry-in or operand inversion shows up in the next sample.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  // Register lane indices
  localparam logic [1:0] REG_A = 2'd0;
  localparam logic [1:0] REG_X = 2'd1;
  localparam logic [1:0] REG_Y = 2'd2;
  localparam int         NREG  = 3;

  // Flag vector positions {N,V,Z,C}
  localparam int FL_N = 3;
  localparam int FL_V = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;
  localparam int NFLAG = 4;

  typedef enum logic [3:0] {
    K_NONE, K_LOAD, K_STORE, K_ALU, K_CMP, K_XFER, K_XSTK, K_STEP,
    K_RMW, K_SHIFTA, K_FLAG, K_BRANCH, K_BIT, K_STATUS
  } kind_e;

  // Strobes from decode control to the datapath
  typedef struct packed {
    kind_e      kind;
    logic [1:0] dst;      // register written or examined
    logic [1:0] src;      // source lane for copies
    logic [2:0] fn;       // operation variant (opcode bits 7:5)
    logic [1:0] flagSel;  // flag position for flag ops and branches
    logic       flagVal;  // value to set, or value tested when taken
    logic       bitMem;   // bit test with memory operand
  } strobe_t;

endpackage

// File: rtl/shadow_control.sv
module shadow_control
  import shadow_pkg::*;
(
  input  logic       recValid,
  input  logic [7:0] recOp,
  output strobe_t    stb
);

  logic [2:0] grp;
  assign grp = recOp[7:5];

  always_comb begin
    stb = '0;
    stb.kind = K_NONE;
    stb.fn = grp;
    if (recValid) begin
      case (recOp)
        8'hA2, 8'hA6, 8'hAE, 8'hB6, 8'hBE: begin stb.kind = K_LOAD;  stb.dst = REG_X; end
        8'hA0, 8'hA4, 8'hAC, 8'hB4, 8'hBC: begin stb.kind = K_LOAD;  stb.dst = REG_Y; end
        8'h68:                             begin stb.kind = K_LOAD;  stb.dst = REG_A; end
        8'h86, 8'h8E, 8'h96:               begin stb.kind = K_STORE; stb.dst = REG_X; end
        8'h84, 8'h8C, 8'h94:               begin stb.kind = K_STORE; stb.dst = REG_Y; end
        8'h48:                             begin stb.kind = K_STORE; stb.dst = REG_A; end
        8'hAA: begin stb.kind = K_XFER; stb.dst = REG_X; stb.src = REG_A; end
        8'hA8: begin stb.kind = K_XFER; stb.dst = REG_Y; stb.src = REG_A; end
        8'h8A: begin stb.kind = K_XFER; stb.dst = REG_A; stb.src = REG_X; end
        8'h98: begin stb.kind = K_XFER; stb.dst = REG_A; stb.src = REG_Y; end
        8'hBA: begin stb.kind = K_XSTK; stb.dst = REG_X; end
        8'hE8: begin stb.kind = K_STEP; stb.dst = REG_X; stb.fn = 3'd0; end
        8'hC8: begin stb.kind = K_STEP; stb.dst = REG_Y; stb.fn = 3'd0; end
        8'hCA: begin stb.kind = K_STEP; stb.dst = REG_X; stb.fn = 3'd1; end
        8'h88: begin stb.kind = K_STEP; stb.dst = REG_Y; stb.fn = 3'd1; end
        8'hE0, 8'hE4, 8'hEC: begin stb.kind = K_CMP; stb.dst = REG_X; end
        8'hC0, 8'hC4, 8'hCC: begin stb.kind = K_CMP; stb.dst = REG_Y; end
        8'h0A, 8'h2A, 8'h4A, 8'h6A: begin stb.kind = K_SHIFTA; stb.dst = REG_A; end
        8'h18: begin stb.kind = K_FLAG; stb.flagSel = 2'(FL_C); stb.flagVal = 1'b0; end
        8'h38: begin stb.kind = K_FLAG; stb.flagSel = 2'(FL_C); stb.flagVal = 1'b1; end
        8'hB8: begin stb.kind = K_FLAG; stb.flagSel = 2'(FL_V); stb.flagVal = 1'b0; end
        8'h24, 8'h2C, 8'h34, 8'h3C: begin stb.kind = K_BIT; stb.dst = REG_A; stb.bitMem = 1'b1; end
        8'h89:                      begin stb.kind = K_BIT; stb.dst = REG_A; stb.bitMem = 1'b0; end
        8'h08, 8'h28:               stb.kind = K_STATUS;
        default: begin
          if (recOp[1:0] == 2'b01) begin
            stb.dst = REG_A;
            case (grp)
              3'b100:  stb.kind = K_STORE;
              3'b101:  stb.kind = K_LOAD;
              3'b110:  stb.kind = K_CMP;
              default: stb.kind = K_ALU;
            endcase
          end else if (recOp[4:0] == 5'b10000) begin
            stb.kind    = K_BRANCH;
            stb.flagVal = recOp[5];
            case (recOp[7:6])
              2'b00:   stb.flagSel = 2'(FL_N);
              2'b01:   stb.flagSel = 2'(FL_V);
              2'b10:   stb.flagSel = 2'(FL_C);
              default: stb.flagSel = 2'(FL_Z);
            endcase
          end else if (recOp[1:0] == 2'b10 && recOp[2] &&
                       grp != 3'b100 && grp != 3'b101) begin
            stb.kind = K_RMW;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/shadow_datapath.sv
module shadow_datapath
  import shadow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] busByte,
  input  logic          taken,
  output logic [DW-1:0] aVal,
  output logic          aKnown,
  output logic [DW-1:0] xVal,
  output logic          xKnown,
  output logic [DW-1:0] yVal,
  output logic          yKnown,
  output logic [NFLAG-1:0] fv,
  output logic [NFLAG-1:0] fk
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] rv [NREG];
  logic          rk [NREG];

  logic [DW-1:0] srcV, dstV, wrV, res, opB;
  logic          srcK, dstK, wr, wrK, okK, arith, rot, left, cin, cout;
  logic [DW:0]   sum;
  logic [NFLAG-1:0] nf, nfk;

  // Source and destination lane muxes
  always_comb begin
    case (stb.src)
      REG_X:   begin srcV = rv[1]; srcK = rk[1]; end
      REG_Y:   begin srcV = rv[2]; srcK = rk[2]; end
      default: begin srcV = rv[0]; srcK = rk[0]; end
    endcase
    case (stb.dst)
      REG_X:   begin dstV = rv[1]; dstK = rk[1]; end
      REG_Y:   begin dstV = rv[2]; dstK = rk[2]; end
      default: begin dstV = rv[0]; dstK = rk[0]; end
    endcase
  end

  // Next-state computation
  always_comb begin
    wr = 1'b0; wrV = dstV; wrK = dstK;
    nf = fv; nfk = fk;
    res = '0; sum = '0; opB = busByte; okK = 1'b0;
    arith = 1'b0; rot = 1'b0; left = 1'b0; cin = 1'b0; cout = 1'b0;
    case (stb.kind)
      K_LOAD: begin
        wr = 1'b1; wrV = busByte; wrK = 1'b1;
        nf[FL_N] = busByte[MSB]; nf[FL_Z] = (busByte == '0);
        nfk[FL_N] = 1'b1; nfk[FL_Z] = 1'b1;
      end
      K_STORE: begin
        wr = 1'b1; wrV = busByte; wrK = 1'b1;
      end
      K_XFER: begin
        wr = 1'b1; wrV = srcV; wrK = srcK;
        nf[FL_N] = srcV[MSB]; nf[FL_Z] = (srcV == '0);
        nfk[FL_N] = srcK; nfk[FL_Z] = srcK;
      end
      K_XSTK: begin
        wr = 1'b1; wrK = 1'b0;
        nfk[FL_N] = 1'b0; nfk[FL_Z] = 1'b0;
      end
      K_STEP: begin
        wr = 1'b1;
        wrV = stb.fn[0] ? dstV - 1'b1 : dstV + 1'b1;
        nf[FL_N] = wrV[MSB]; nf[FL_Z] = (wrV == '0);
        nfk[FL_N] = dstK; nfk[FL_Z] = dstK;
      end
      K_CMP: begin
        sum = {1'b0, dstV} - {1'b0, busByte};
        nf[FL_C] = ~sum[DW]; nf[FL_N] = sum[MSB]; nf[FL_Z] = (sum[MSB:0] == '0);
        nfk[FL_C] = dstK; nfk[FL_N] = dstK; nfk[FL_Z] = dstK;
      end
      K_ALU: begin
        arith = (stb.fn == 3'b011) || (stb.fn == 3'b111);
        opB   = (stb.fn == 3'b111) ? ~busByte : busByte;
        sum   = {1'b0, dstV} + {1'b0, opB} + {{DW{1'b0}}, fv[FL_C]};
        case (stb.fn)
          3'b000:  res = dstV | busByte;
          3'b001:  res = dstV & busByte;
          3'b010:  res = dstV ^ busByte;
          default: res = sum[MSB:0];
        endcase
        okK = dstK & (~arith | fk[FL_C]);
        wr = 1'b1; wrV = res; wrK = okK;
        nf[FL_N] = res[MSB]; nf[FL_Z] = (res == '0);
        nfk[FL_N] = okK; nfk[FL_Z] = okK;
        if (arith) begin
          nf[FL_C]  = sum[DW];
          nf[FL_V]  = (dstV[MSB] == opB[MSB]) && (res[MSB] != dstV[MSB]);
          nfk[FL_C] = okK; nfk[FL_V] = okK;
        end
      end
      K_SHIFTA: begin
        rot  = stb.fn[0];
        left = ~stb.fn[1];
        cin  = rot & fv[FL_C];
        res  = left ? {dstV[MSB-1:0], cin} : {cin, dstV[MSB:1]};
        cout = left ? dstV[MSB] : dstV[0];
        okK  = dstK & (~rot | fk[FL_C]);
        wr = 1'b1; wrV = res; wrK = okK;
        nf[FL_N] = res[MSB]; nf[FL_Z] = (res == '0); nf[FL_C] = cout;
        nfk[FL_N] = okK; nfk[FL_Z] = okK; nfk[FL_C] = okK;
      end
      K_RMW: begin
        nf[FL_N] = busByte[MSB]; nf[FL_Z] = (busByte == '0);
        nfk[FL_N] = 1'b1; nfk[FL_Z] = 1'b1;
        if (!stb.fn[2]) nfk[FL_C] = 1'b0;
      end
      K_FLAG: begin
        nf[stb.flagSel] = stb.flagVal; nfk[stb.flagSel] = 1'b1;
      end
      K_BRANCH: begin
        nf[stb.flagSel] = taken ? stb.flagVal : ~stb.flagVal;
        nfk[stb.flagSel] = 1'b1;
      end
      K_BIT: begin
        nf[FL_Z] = ((dstV & busByte) == '0); nfk[FL_Z] = dstK;
        if (stb.bitMem) begin
          nf[FL_N] = busByte[MSB]; nf[FL_V] = busByte[MSB-1];
          nfk[FL_N] = 1'b1; nfk[FL_V] = 1'b1;
        end
      end
      K_STATUS: begin
        nf  = {busByte[MSB], busByte[MSB-1], busByte[1], busByte[0]};
        nfk = '1;
      end
      default: ;
    endcase
  end

  // One register lane per tracked register
  for (genvar i = 0; i < NREG; i++) begin : g_lane
    logic [DW-1:0] laneV;
    logic          laneK;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneV <= '0;
        laneK <= 1'b0;
      end else if (wr && stb.dst == 2'(i)) begin
        laneV <= wrV;
        laneK <= wrK;
      end
    end
    assign rv[i] = laneV;
    assign rk[i] = laneK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fv <= '0;
      fk <= '0;
    end else begin
      fv <= nf;
      fk <= nfk;
    end
  end

  assign aVal = rv[0]; assign aKnown = rk[0];
  assign xVal = rv[1]; assign xKnown = rk[1];
  assign yVal = rv[2]; assign yKnown = rk[2];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == K_NONE |=> $stable({aKnown, xKnown, yKnown, fk, fv, aVal, xVal, yVal})); // R2
  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == K_LOAD && stb.dst == REG_A |=> aKnown && aVal == $past(busByte)); // R3
  AST_STORE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == K_STORE |=> $stable(fv) && $stable(fk)); // R4
  AST_BRANCH_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == K_BRANCH && stb.flagSel == 2'(FL_C) |=> fk[FL_C]); // R12
  AST_STATUS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == K_STATUS |=> fk == '1); // R14
  AST_RMW_REGS: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == K_RMW |=> $stable({aVal, xVal, yVal, aKnown, xKnown, yKnown})); // R10

endmodule

// File: rtl/shadow_tracker.sv
module shadow_tracker
  import shadow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          recValid,
  input  logic [7:0]    recOp,
  input  logic [DW-1:0] recData,
  input  logic          recTaken,
  output logic [DW-1:0] shadowA,
  output logic          shadowAKnown,
  output logic [DW-1:0] shadowX,
  output logic          shadowXKnown,
  output logic [DW-1:0] shadowY,
  output logic          shadowYKnown,
  output logic [3:0]    flags,
  output logic [3:0]    flagsKnown
);

  strobe_t stb;

  shadow_control u_ctrl (
    .recValid (recValid),
    .recOp    (recOp),
    .stb      (stb)
  );

  shadow_datapath #(.DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busByte (recData),
    .taken   (recTaken),
    .aVal    (shadowA),
    .aKnown  (shadowAKnown),
    .xVal    (shadowX),
    .xKnown  (shadowXKnown),
    .yVal    (shadowY),
    .yKnown  (shadowYKnown),
    .fv      (flags),
    .fk      (flagsKnown)
  );

  AST_STACK_COPY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recOp == 8'h9A |=> $stable({shadowA, shadowX, shadowY, shadowAKnown,
                                            shadowXKnown, shadowYKnown, flags, flagsKnown})); // R8
  AST_STACK_READ_UNKNOWN: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recOp == 8'hBA |=> !shadowXKnown && !flagsKnown[3] && !flagsKnown[1]); // R7

endmodule

// File: tb/sim_shadow_tracker.sv
`timescale 1ns/1ps
module sim_shadow_tracker;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       recValid = 1'b0;
  logic [7:0] recOp = '0;
  logic [7:0] recData = '0;
  logic       recTaken = 1'b0;
  logic [7:0] shadowA, shadowX, shadowY;
  logic       shadowAKnown, shadowXKnown, shadowYKnown;
  logic [3:0] flags, flagsKnown;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shadow_tracker u0 (
    .clk, .rstN, .recValid, .recOp, .recData, .recTaken,
    .shadowA, .shadowAKnown, .shadowX, .shadowXKnown, .shadowY, .shadowYKnown,
    .flags, .flagsKnown
  );

  typedef struct packed {
    logic [7:0] op;  logic [7:0] dat; logic tkn;
    logic [7:0] eA;  logic eAk;
    logic [7:0] eX;  logic eXk;
    logic [7:0] eY;  logic eYk;
    logic [3:0] eF;  logic [3:0] eFk;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 50;
  // Flags are {N,V,Z,C}; values are compared only where expected known.
  localparam logic [55:0] TBL [NV] = '{
    {8'hA9,8'h00,1'b0, 8'h00,1'b1, 8'h00,1'b0, 8'h00,1'b0, 4'b0010,4'b1010, 4'd3},  // R3
    {8'hA2,8'h80,1'b0, 8'h00,1'b1, 8'h80,1'b1, 8'h00,1'b0, 4'b1000,4'b1010, 4'd3},  // R3
    {8'h84,8'h5A,1'b0, 8'h00,1'b1, 8'h80,1'b1, 8'h5A,1'b1, 4'b1000,4'b1010, 4'd4},  // R4
    {8'h38,8'h00,1'b0, 8'h00,1'b1, 8'h80,1'b1, 8'h5A,1'b1, 4'b1001,4'b1011, 4'd12}, // R12
    {8'h69,8'h05,1'b0, 8'h06,1'b1, 8'h80,1'b1, 8'h5A,1'b1, 4'b0000,4'b1111, 4'd5},  // R5
    {8'hE9,8'h10,1'b0, 8'hF5,1'b1, 8'h80,1'b1, 8'h5A,1'b1, 4'b1000,4'b1111, 4'd5},  // R5
    {8'hC9,8'hF5,1'b0, 8'hF5,1'b1, 8'h80,1'b1, 8'h5A,1'b1, 4'b0011,4'b1111, 4'd6},  // R6
    {8'hAA,8'h00,1'b0, 8'hF5,1'b1, 8'hF5,1'b1, 8'h5A,1'b1, 4'b1001,4'b1111, 4'd7},  // R7
    {8'hE8,8'h00,1'b0, 8'hF5,1'b1, 8'hF6,1'b1, 8'h5A,1'b1, 4'b1001,4'b1111, 4'd9},  // R9
    {8'h9A,8'h33,1'b0, 8'hF5,1'b1, 8'hF6,1'b1, 8'h5A,1'b1, 4'b1001,4'b1111, 4'd8},  // R8
    {8'h88,8'h00,1'b0, 8'hF5,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b0001,4'b1111, 4'd9},  // R9
    {8'h29,8'h0F,1'b0, 8'h05,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b0001,4'b1111, 4'd5},  // R5
    {8'h49,8'h05,1'b0, 8'h00,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b0011,4'b1111, 4'd5},  // R5
    {8'h09,8'h81,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1001,4'b1111, 4'd5},  // R5
    {8'h0A,8'h00,1'b0, 8'h02,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b0001,4'b1111, 4'd11}, // R11
    {8'h6A,8'h00,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1000,4'b1111, 4'd11}, // R11
    {8'h4A,8'h00,1'b0, 8'h40,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b0001,4'b1111, 4'd11}, // R11
    {8'h2A,8'h00,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1000,4'b1111, 4'd11}, // R11
    {8'h2C,8'hC0,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1100,4'b1111, 4'd13}, // R13
    {8'h89,8'h7E,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1110,4'b1111, 4'd13}, // R13
    {8'hB8,8'h00,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1010,4'b1111, 4'd12}, // R12
    {8'h18,8'h00,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1010,4'b1111, 4'd12}, // R12
    {8'hEE,8'h00,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b0010,4'b1111, 4'd10}, // R10
    {8'h06,8'h80,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1000,4'b1110, 4'd10}, // R10
    {8'hB0,8'h00,1'b1, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1001,4'b1111, 4'd12}, // R12
    {8'hD0,8'h00,1'b0, 8'h81,1'b1, 8'hF6,1'b1, 8'h59,1'b1, 4'b1011,4'b1111, 4'd12}, // R12
    {8'hBA,8'h00,1'b0, 8'h81,1'b1, 8'h00,1'b0, 8'h59,1'b1, 4'b0001,4'b0101, 4'd7},  // R7
    {8'hCA,8'h00,1'b0, 8'h81,1'b1, 8'h00,1'b0, 8'h59,1'b1, 4'b0001,4'b0101, 4'd9},  // R9
    {8'hE0,8'h10,1'b0, 8'h81,1'b1, 8'h00,1'b0, 8'h59,1'b1, 4'b0000,4'b0100, 4'd6},  // R6
    {8'hA6,8'hFF,1'b0, 8'h81,1'b1, 8'hFF,1'b1, 8'h59,1'b1, 4'b1000,4'b1110, 4'd3},  // R3
    {8'h69,8'h01,1'b0, 8'h00,1'b0, 8'hFF,1'b1, 8'h59,1'b1, 4'b0000,4'b0000, 4'd5},  // R5
    {8'h29,8'h00,1'b0, 8'h00,1'b0, 8'hFF,1'b1, 8'h59,1'b1, 4'b0000,4'b0000, 4'd5},  // R5
    {8'hA8,8'h00,1'b0, 8'h00,1'b0, 8'hFF,1'b1, 8'h00,1'b0, 4'b0000,4'b0000, 4'd7},  // R7
    {8'h28,8'hC3,1'b0, 8'h00,1'b0, 8'hFF,1'b1, 8'h00,1'b0, 4'b1111,4'b1111, 4'd14}, // R14
    {8'h48,8'h3C,1'b0, 8'h3C,1'b1, 8'hFF,1'b1, 8'h00,1'b0, 4'b1111,4'b1111, 4'd4},  // R4
    {8'hA8,8'h00,1'b0, 8'h3C,1'b1, 8'hFF,1'b1, 8'h3C,1'b1, 4'b0101,4'b1111, 4'd7},  // R7
    {8'hC0,8'h3D,1'b0, 8'h3C,1'b1, 8'hFF,1'b1, 8'h3C,1'b1, 4'b1100,4'b1111, 4'd6},  // R6
    {8'h8E,8'h42,1'b0, 8'h3C,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b1100,4'b1111, 4'd4},  // R4
    {8'h8A,8'h00,1'b0, 8'h42,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b0100,4'b1111, 4'd7},  // R7
    {8'h4C,8'h12,1'b0, 8'h42,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b0100,4'b1111, 4'd2},  // R2
    {8'h30,8'h00,1'b1, 8'h42,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b1100,4'b1111, 4'd12}, // R12
    {8'h50,8'h00,1'b1, 8'h42,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b1000,4'b1111, 4'd12}, // R12
    {8'h68,8'h00,1'b0, 8'h00,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b0010,4'b1111, 4'd3},  // R3
    {8'h69,8'h7F,1'b0, 8'h7F,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b0000,4'b1111, 4'd5},  // R5
    {8'h69,8'h01,1'b0, 8'h80,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b1100,4'b1111, 4'd5},  // R5
    {8'h98,8'h00,1'b0, 8'h3C,1'b1, 8'h42,1'b1, 8'h3C,1'b1, 4'b0100,4'b1111, 4'd7},  // R7
    {8'hA0,8'h00,1'b0, 8'h3C,1'b1, 8'h42,1'b1, 8'h00,1'b1, 4'b0110,4'b1111, 4'd3},  // R3
    {8'h88,8'h00,1'b0, 8'h3C,1'b1, 8'h42,1'b1, 8'hFF,1'b1, 4'b1100,4'b1111, 4'd9},  // R9
    {8'hC8,8'h00,1'b0, 8'h3C,1'b1, 8'h42,1'b1, 8'h00,1'b1, 4'b0110,4'b1111, 4'd9},  // R9
    {8'hE8,8'h00,1'b0, 8'h3C,1'b1, 8'h43,1'b1, 8'h00,1'b1, 4'b0100,4'b1111, 4'd9}   // R9
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit match(input logic [7:0] v, input logic k,
                               input logic [7:0] ev, input logic ek);
    return (k == ek) && (!ek || v == ev);
  endfunction

  task automatic check_all_unknown(input string req);
    check({shadowAKnown, shadowXKnown, shadowYKnown, flagsKnown} == 7'd0, req,
          "known bits after reset", {25'd0, shadowAKnown, shadowXKnown, shadowYKnown, flagsKnown}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all_unknown("R1");                // reset state
    rstN = 1'b1;
    @(negedge clk);
    check_all_unknown("R1");                // still unknown with no records

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      recOp = v.op; recData = v.dat; recTaken = v.tkn; recValid = 1'b1;
      @(negedge clk);
      check(match(shadowA, shadowAKnown, v.eA, v.eAk) &&
            match(shadowX, shadowXKnown, v.eX, v.eXk) &&
            match(shadowY, shadowYKnown, v.eY, v.eYk) &&
            (flagsKnown == v.eFk) && ((flags & v.eFk) == (v.eF & v.eFk)),
            $sformatf("R%0d", v.req), $sformatf("row %0d op %h", i, v.op),
            {shadowA, shadowX, shadowY, flagsKnown, flags & flagsKnown},
            {v.eA, v.eX, v.eY, v.eFk, v.eF & v.eFk});
    end

    // R2: a load presented with recValid low is ignored
    recValid = 1'b0; recOp = 8'hA9; recData = 8'h55;
    @(negedge clk); @(negedge clk);
    check(shadowA == 8'h3C && shadowAKnown, "R2", "A with recValid low",
          {23'd0, shadowAKnown, shadowA}, {23'd0, 1'b1, 8'h3C});
    check(flags == 4'b0100 && flagsKnown == 4'hF, "R2", "flags with recValid low",
          {24'd0, flagsKnown, flags}, {24'd0, 4'hF, 4'b0100});

    // R2: unlisted opcode (0xEA) with valid record changes nothing
    recValid = 1'b1; recOp = 8'hEA; recData = 8'h00;
    @(negedge clk);
    recValid = 1'b0;
    check(shadowX == 8'h43 && shadowXKnown && shadowY == 8'h00 && shadowYKnown, "R2",
          "X/Y after unlisted opcode", {16'd0, shadowX, shadowY}, {16'd0, 8'h43, 8'h00});

    // R1: reset mid-run clears every known bit
    rstN = 1'b0;
    @(negedge clk);
    check_all_unknown("R1");
    rstN = 1'b1;

    // R13: bit test with unknown A gives N,V but not Z
    recValid = 1'b1; recOp = 8'h24; recData = 8'h40;
    @(negedge clk);
    recValid = 1'b0;
    check(flagsKnown == 4'b1100 && flags[3:2] == 2'b01, "R13", "bit test with unknown A",
          {24'd0, flagsKnown, flags}, {24'd0, 4'b1100, 4'b0100});

    // R11: rotate with unknown carry leaves A unknown after a load
    recValid = 1'b1; recOp = 8'hA9; recData = 8'h01;
    @(negedge clk);
    recOp = 8'h2A;
    @(negedge clk);
    recValid = 1'b0;
    check(!shadowAKnown && flagsKnown == 4'b0100, "R11", "rotate with unknown carry",
          {27'd0, shadowAKnown, flagsKnown}, {27'd0, 1'b0, 4'b0100});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule